// File: doc/BRIEF.md
# Two-Word Shift-and-XOR Binary Polynomial Multiplier

This block multiplies binary polynomials one machine word at a time. Its core is a chain of shift stages: each stage moves the running multiplicand one place to the left, and bit r of the multiplier word decides whether stage r's value joins an XOR accumulator. A single mode select picks one of two behaviours.

In reduce mode, a bit that falls off the top of a stage folds back into that stage through the supplied low terms of a degree-32 irreducible polynomial. The word that comes out is the field product.

In window mode, the polynomial input is masked to zero. The bit that stage r's shift frees at the bottom is then filled from a second, lower-order multiplicand word. This turns the result into one aligned word of a multi-word partial product. Software that reduces large fields calls the block once for each output word and gets that word directly, with no 64-bit product to split and recombine.

Operands enter on a valid/ready handshake, and the result leaves on another. The input is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result the consumer has not taken stays on `out_data`, unchanged, until `out_ready` is seen high. While it waits, no new input is accepted, and a producer may hold `in_valid` high across the stall.

Top module: `gf2_window_mul`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R2: An input is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R3: The result of an accepted input appears on `out_data` with `out_valid` = 1 on the cycle after acceptance, so a new operand set can be accepted every cycle while `out_ready` stays high.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values and no input is taken. When `out_ready` returns, the held word is consumed and a waiting input is accepted on the same edge.
- R5: With `mode_sel` = 1 (reduce mode), `out_data` equals `mult_a`·`mult_b` mod (x^32 + `irr_poly`), where bit i of each word is the coefficient of x^i. `mult_a_prev` has no effect in this mode.
- R6: With `mode_sel` = 0 (window mode), `out_data` is the XOR over r = 0..31 of bit r of `mult_b` AND-ed with the low 32 bits of ((`mult_a` << r) | (`mult_a_prev` >> (32 − r))). This equals bits 63..32 of the carry-less product of the 64-bit word {`mult_a`, `mult_a_prev`} and `mult_b`. `irr_poly` has no effect in this mode.
- R7: In both modes, `mult_b` = 0 gives 0 and `mult_b` = 1 gives `mult_a`, because stage 0 takes no fill bit and no reduction.
- R8: In window mode with `mult_b` = 2^31, the result is (`mult_a` << 31) | (`mult_a_prev` >> 1), which shows the last stage's fill. In window mode with `mult_a_prev` = 0 and `mult_b` = 2, the result is `mult_a` << 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set on the inputs is valid |
| in_ready | output | 1 | Block can take an operand set this cycle |
| mode_sel | input | 1 | 1 = reduce mode, 0 = window mode |
| mult_a | input | 32 | Multiplicand word (the current word in window mode) |
| mult_a_prev | input | 32 | Next lower multiplicand word (window mode only) |
| mult_b | input | 32 | Multiplier word; bit r gates stage r |
| irr_poly | input | 32 | Irreducible polynomial without its x^32 term (reduce mode only) |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes `out_data` this cycle |
| out_data | output | 32 | Result word |

## Verification
The hardest case to reach from the ports is a cycle that does three things at once: it drains a stalled result, accepts a waiting operand set, and presents the new result one cycle later. The bench holds `out_ready` low with a second operand set already waiting on the inputs, then raises `out_ready` and checks that the second result follows directly. The fill path of the last stage is also hard to isolate, because it only shows once the other stages are silenced. The stimulus uses `mult_b` = 2^31 with chosen bit patterns, and runs the same vectors again with the ignored operand changed, so that a leak through either mask shows on `out_data`.

// File: rtl/gf2wm_pkg.sv
package gf2wm_pkg;
  localparam int unsigned WORD_W = 32;
  typedef enum logic {
    MODE_WINDOW = 1'b0,
    MODE_REDUCE = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/gf2wm_stage.sv
module gf2wm_stage #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] poly,
  input  logic         reduce_en,
  input  logic         fill_bit,
  output logic [W-1:0] nxt
);
  logic [W-1:0] poly_masked;
  logic         fill_masked;

  // reduction terms only in reduce mode, fill bit only in window mode
  assign poly_masked = poly & {W{reduce_en}};
  assign fill_masked = fill_bit & ~reduce_en;
  assign nxt = {cur[W-2:0], fill_masked} ^ (cur[W-1] ? poly_masked : '0);
endmodule

// File: rtl/gf2wm_array.sv
module gf2wm_array #(
  parameter int unsigned W = 32
) (
  input  logic         reduce_en,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opa_prev,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] poly,
  output logic [W-1:0] product
);
  logic [W-1:0] shifted [W];
  logic [W-1:0] gated   [W];
  logic         unused_prev_lsb;

  // word shifted in from the low operand; its bit 0 is never reached
  assign unused_prev_lsb = opa_prev[0];
  assign shifted[0] = opa;

  for (genvar r = 1; r < W; r++) begin : g_stage
    gf2wm_stage #(.W(W)) u_stage (
      .cur       (shifted[r-1]),
      .poly      (poly),
      .reduce_en (reduce_en),
      .fill_bit  (opa_prev[W-r]),
      .nxt       (shifted[r])
    );
  end

  for (genvar r = 0; r < W; r++) begin : g_gate
    assign gated[r] = shifted[r] & {W{opb[r]}};
  end

  always_comb begin
    product = '0;
    for (int r = 0; r < W; r++) begin
      product = product ^ gated[r];
    end
  end
endmodule

// File: rtl/gf2wm_outreg.sv
module gf2wm_outreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
    end else if (take) begin
      dn_valid <= 1'b1;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_data <= '0;
    end else if (take) begin
      dn_data <= up_data;
    end
  end
endmodule

// File: rtl/gf2_window_mul.sv
module gf2_window_mul
  import gf2wm_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         mode_sel,
  input  logic [W-1:0] mult_a,
  input  logic [W-1:0] mult_a_prev,
  input  logic [W-1:0] mult_b,
  input  logic [W-1:0] irr_poly,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  mul_mode_e    mode;
  logic [W-1:0] comb_product;

  assign mode = mul_mode_e'(mode_sel);

  gf2wm_array #(.W(W)) u_array (
    .reduce_en (mode == MODE_REDUCE),
    .opa       (mult_a),
    .opa_prev  (mult_a_prev),
    .opb       (mult_b),
    .poly      (irr_poly),
    .product   (comb_product)
  );

  gf2wm_outreg #(.W(W)) u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (comb_product),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: rtl/gf2wm_chk.sv
module gf2wm_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         mode_sel,
  input logic [W-1:0] mult_a,
  input logic [W-1:0] mult_a_prev,
  input logic [W-1:0] mult_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  accept_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (!out_valid || out_ready));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  unit_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mult_b == W'(1)) |=> (out_data == $past(mult_a)));

  // R7
  zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mult_b == '0) |=> (out_data == '0));

  // R8
  window_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode_sel && mult_a_prev == '0 && mult_b == W'(2))
    |=> (out_data == ($past(mult_a) << 1)));
endmodule

bind gf2_window_mul gf2wm_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .mode_sel    (mode_sel),
  .mult_a      (mult_a),
  .mult_a_prev (mult_a_prev),
  .mult_b      (mult_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/tb_gf2_window_mul.sv
`timescale 1ns/1ps
module tb_gf2_window_mul;
  localparam int unsigned W = 32;
  localparam int NVEC = 12;
  // {mode, a, a_prev, b, poly}
  localparam logic [128:0] VEC [NVEC] = '{
    {1'b1, 32'h1234_5678, 32'h0000_0000, 32'h9ABC_DEF0, 32'h0000_008D},
    {1'b1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_008D},
    {1'b1, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0040_0007},
    {1'b1, 32'hCAFE_F00D, 32'h5555_5555, 32'h0000_0003, 32'h0000_00AF},
    {1'b1, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 32'h0000_008D},
    {1'b1, 32'h0000_0001, 32'h1111_1111, 32'hA5A5_A5A5, 32'h0000_0005},
    {1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h0000_008D},
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 32'h0000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFF},
    {1'b0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h8000_0001, 32'h0000_008D},
    {1'b0, 32'h8000_0000, 32'h0000_0000, 32'h0001_0000, 32'h1234_5678},
    {1'b0, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h0000_00AF}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         mode_sel = 1'b0;
  logic [W-1:0] mult_a = '0;
  logic [W-1:0] mult_a_prev = '0;
  logic [W-1:0] mult_b = '0;
  logic [W-1:0] irr_poly = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gf2_window_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode_sel(mode_sel), .mult_a(mult_a), .mult_a_prev(mult_a_prev),
    .mult_b(mult_b), .irr_poly(irr_poly), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [95:0] clmul(input logic [63:0] x, input logic [31:0] y);
    logic [95:0] acc = '0;
    for (int i = 0; i < 32; i++) if (y[i]) acc = acc ^ ({32'b0, x} << i);
    return acc;
  endfunction

  function automatic logic [31:0] ref_model(input logic [128:0] v);
    logic [95:0] p;
    logic [63:0] q;
    if (v[128]) begin
      p = clmul({32'b0, v[127:96]}, v[63:32]);
      q = p[63:0];
      for (int i = 63; i >= 32; i--)
        if (q[i]) q = q ^ ({31'b0, 1'b1, v[31:0]} << (i - 32));
      return q[31:0];
    end
    p = clmul({v[127:96], v[95:64]}, v[63:32]);
    return p[63:32];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [128:0] v);
    mode_sel = v[128]; mult_a = v[127:96]; mult_a_prev = v[95:64];
    mult_b = v[63:32]; irr_poly = v[31:0]; in_valid = 1'b1;
  endtask

  task automatic run_one(input logic [128:0] v, input logic [31:0] exp, input string req);
    @(negedge clk); out_ready = 1'b1; drive(v);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " valid (R3)"}, {31'b0, out_valid}, 32'h1);
    check(out_data == exp, req, out_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [128:0] v;
    logic [31:0] e;
    // R1 reset state
    repeat (2) @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
    check(in_ready, "R1 in_ready in reset", {31'b0, in_ready}, 32'h1);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R5 reduce mode, R6 window mode
    for (int k = 0; k < NVEC; k++) begin
      run_one(VEC[k], ref_model(VEC[k]), VEC[k][128] ? "R5 table" : "R6 table");
    end

    // R5: a_prev ignored in reduce mode
    v = VEC[0]; e = ref_model(v); v[95:64] = 32'hFFFF_FFFF;
    run_one(v, e, "R5 a_prev ignored");
    // R6: poly ignored in window mode
    v = VEC[6]; e = ref_model(v); v[31:0] = 32'hFFFF_FFFF;
    run_one(v, e, "R6 poly ignored");
    // R5 hand value: x^31 * x mod (x^32 + x^7+x^3+x^2+1)
    run_one({1'b1, 32'h8000_0000, 32'h0, 32'h2, 32'h8D}, 32'h0000_008D, "R5 single fold");
    // R7 unit and zero multiplier in both modes
    run_one({1'b1, 32'h3C3C_1234, 32'h0, 32'h1, 32'h8D}, 32'h3C3C_1234, "R7 unit reduce");
    run_one({1'b0, 32'h3C3C_1234, 32'hFFFF_FFFF, 32'h1, 32'h8D}, 32'h3C3C_1234, "R7 unit window");
    run_one({1'b0, 32'h3C3C_1234, 32'hFFFF_FFFF, 32'h0, 32'h8D}, 32'h0, "R7 zero window");
    // R8 last-stage fill and plain shift
    run_one({1'b0, 32'h0000_0001, 32'h8000_0000, 32'h8000_0000, 32'h0}, 32'hC000_0000, "R8 stage31 fill");
    run_one({1'b0, 32'h8000_0003, 32'h0, 32'h2, 32'hFFFF_FFFF}, 32'h0000_0006, "R8 shift no fold");

    // R4 back-pressure with a waiting input, R2 simultaneous drain and accept
    @(negedge clk); out_ready = 1'b0; drive(VEC[1]);
    @(negedge clk); drive(VEC[7]);
    check(!in_ready, "R2 in_ready low when stalled", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    check(out_valid && out_data == ref_model(VEC[1]), "R4 hold under stall", out_data, ref_model(VEC[1]));
    @(negedge clk);
    check(out_valid && out_data == ref_model(VEC[1]), "R4 hold second cycle", out_data, ref_model(VEC[1]));
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check(out_valid && out_data == ref_model(VEC[7]), "R4 drain and accept", out_data, ref_model(VEC[7]));
    @(negedge clk);
    check(!out_valid, "R2 empty after drain", {31'b0, out_valid}, 32'h0);

    // R3 back-to-back stream
    for (int k = 2; k < 7; k++) begin
      @(negedge clk);
      if (k > 2) check(out_valid && out_data == ref_model(VEC[k-1]), "R3 stream", out_data, ref_model(VEC[k-1]));
      drive(VEC[k]);
    end
    @(negedge clk); in_valid = 1'b0;
    check(out_valid && out_data == ref_model(VEC[6]), "R3 stream last", out_data, ref_model(VEC[6]));

    // R1 reset with a pending result
    @(negedge clk); out_ready = 1'b0; drive(VEC[3]);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    #1;
    check(!out_valid, "R1 reset clears pending", {31'b0, out_valid}, 32'h0);
    check(in_ready, "R1 ready during reset", {31'b0, in_ready}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule